// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a register-mapped watchdog. A down-counter is loaded by software and, once counting is switched on, drops by one every clock cycle. When it reaches zero the watchdog records a pending event and can request an interrupt, a system reset, or both. Stray writes are kept from disturbing it: the counter and the control register accept writes only while a fixed unlock code sits in the key register. Writing anything else to the key register locks them again.

A status register holds two flags. One marks a pending expiry. The other is sticky and tells boot software that the previous reset came from the watchdog. The warm reset clears every other piece of state but leaves this flag alone; only power-on reset or a write-one-to-clear removes it. The reset request is a pulse of fixed, parameterised length. It is meant to drive the chip's warm reset network, which lies outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset the counter, control and status read 0, the key register reads 0 (locked), and irq and reset_req are low.
- R2: Writing 0x0000482E to the key register (offset 0x1C) unlocks it. Writing any other value locks it. A read of the key register returns 1 while unlocked and 0 while locked.
- R3: A write to the counter (offset 0x14) or to the control register (offset 0x18) while locked is ignored, and a read returns the earlier value.
- R4: Control bit 0 enables the reset request, bit 1 enables the interrupt and bit 2 enables counting. Reads of the control register return these three bits.
- R5: While counting is enabled and the counter is not zero, it drops by exactly one per clock cycle. While counting is disabled it holds its value.
- R6: On the first cycle the counter is zero with counting enabled after a load, status bit 3 (pending) is set on the next clock edge. The counter stays at zero and does not wrap.
- R7: irq is high exactly while status bit 3 is set and control bit 1 is set.
- R8: When an expiry occurs with control bit 0 set, reset_req rises on the same edge as pending and stays high for PULSE_CYCLES cycles. A second expiry needs a new counter load.
- R9: Status bit 4 (watchdog-caused reset) is set when reset_req starts. It survives the warm reset and is cleared only by power-on reset or by writing 1 to it.
- R10: Writing 1 to status bit 3 or bit 4 (offset 0x20) clears that bit. Writing 0 leaves it unchanged. Status writes need no unlock.
- R11: Loading 0 into the counter and then enabling counting and reset produces reset_req one cycle after the control write takes effect.
- R12: A warm reset clears the counter, control, key and pending bit. It does not clear status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it is also the count tick |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous; spares status bit 4 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request, level |
| reset_req | output | 1 | Reset request pulse |

## Verification
The embedded assertions check the following on every cycle:
- The counter steps down by one while running, holds while stopped, and never wraps below zero.
- Locked control writes leave the control register unchanged.
- Each expiry sets pending on the next edge, and at most one expiry occurs per load.
- Every reset pulse starts from an expiry, and the sticky flag is set when the pulse starts.
- The sticky flag persists until it is cleared.

Only the bench scenarios can show the following:
- The exact cycle on which pending, irq and reset_req rise after loads of random length.
- The pulse length.
- The readback encodings.
- Which state a warm reset spares compared with a power-on reset.
- The immediate-reset sequence.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

   // Byte offsets decoded on the register bus
   localparam int unsigned OFS_COUNT = 32'h14;
   localparam int unsigned OFS_CTRL  = 32'h18;
   localparam int unsigned OFS_KEY   = 32'h1C;
   localparam int unsigned OFS_STAT  = 32'h20;

   localparam logic [15:0] UNLOCK_CODE = 16'h482E;

   localparam int STAT_PEND = 3;
   localparam int STAT_WARM = 4;

   // Packed: rst_on is bit 0, irq_on bit 1, run bit 2
   typedef struct packed {
      logic run;
      logic irq_on;
      logic rst_on;
   } ctrl_t;

endpackage

// File: rtl/kwd_down_counter.sv
module kwd_down_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              run,
   output logic [DATA_W-1:0] cnt,
   output logic              expire
);

   logic armed;

   assign expire = run && armed && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (load) begin
         cnt   <= load_val;
         armed <= 1'b1;
      end else begin
         if (expire)
            armed <= 1'b0;
         if (run && (cnt != '0))
            cnt <= cnt - 1'b1;
      end
   end

   assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
      (run && cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!run && !load) |=> $stable(cnt));

   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt == '0 && !load) |=> (cnt == '0));

   assert_one_expiry_R8: assert property (@(posedge clk) disable iff (rst)
      (expire && !load) |=> !expire);

endmodule

// File: rtl/kwd_pulse_gen.sv
module kwd_pulse_gen #(
   parameter int PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic trigger,
   output logic pulse
);

   localparam int CW = $clog2(PULSE_CYCLES + 1);

   generate
      if (PULSE_CYCLES < 1) begin : g_bad_len
         $error("PULSE_CYCLES must be at least 1");
      end else if (PULSE_CYCLES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) pulse <= 1'b0;
            else     pulse <= trigger;
         end
      end else begin : g_count
         logic [CW-1:0] left;
         always_ff @(posedge clk) begin
            if (rst)               left <= '0;
            else if (trigger)      left <= CW'(PULSE_CYCLES);
            else if (left != '0)   left <= left - 1'b1;
         end
         assign pulse = (left != '0);
      end
   endgenerate

   assert_pulse_start_R8: assert property (@(posedge clk) disable iff (rst)
      trigger |=> pulse);

   assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse) |-> $past(trigger));

endmodule

// File: rtl/kwd_bus_regs.sv
module kwd_bus_regs
   import keyed_watchdog_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cnt_val,
   input  logic              expire,
   output ctrl_t             ctrl,
   output logic              load_cnt,
   output logic              pending,
   output logic              warm_flag,
   output logic [DATA_W-1:0] rdata
);

   logic soft_rst;
   logic unlocked;
   logic sel_cnt, sel_ctrl, sel_key, sel_stat;
   logic key_match;

   assign soft_rst  = !por_n || !warm_rst_n;
   assign sel_cnt   = (addr == ADDR_W'(OFS_COUNT));
   assign sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
   assign sel_key   = (addr == ADDR_W'(OFS_KEY));
   assign sel_stat  = (addr == ADDR_W'(OFS_STAT));
   assign key_match = (wdata == DATA_W'(UNLOCK_CODE));
   assign load_cnt  = wr_en && sel_cnt && unlocked;

   always_ff @(posedge clk) begin
      if (soft_rst)
         unlocked <= 1'b0;
      else if (wr_en && sel_key)
         unlocked <= key_match;
   end

   always_ff @(posedge clk) begin
      if (soft_rst)
         ctrl <= '0;
      else if (wr_en && sel_ctrl && unlocked)
         ctrl <= ctrl_t'(wdata[2:0]);
   end

   always_ff @(posedge clk) begin
      if (soft_rst)
         pending <= 1'b0;
      else if (expire)
         pending <= 1'b1;
      else if (wr_en && sel_stat && wdata[STAT_PEND])
         pending <= 1'b0;
   end

   // Sticky: only power-on reset clears it, never the warm reset
   always_ff @(posedge clk) begin
      if (!por_n)
         warm_flag <= 1'b0;
      else if (expire && ctrl.rst_on)
         warm_flag <= 1'b1;
      else if (wr_en && sel_stat && wdata[STAT_WARM])
         warm_flag <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (sel_cnt)
         rdata = cnt_val;
      else if (sel_ctrl)
         rdata[2:0] = ctrl;
      else if (sel_key)
         rdata[0] = unlocked;
      else if (sel_stat) begin
         rdata[STAT_PEND] = pending;
         rdata[STAT_WARM] = warm_flag;
      end
   end

   assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (soft_rst)
      (wr_en && sel_ctrl && !unlocked) |=> $stable(ctrl));

   assert_key_state_R2: assert property (@(posedge clk) disable iff (soft_rst)
      (wr_en && sel_key) |=> (unlocked == $past(key_match)));

   assert_pend_set_R6: assert property (@(posedge clk) disable iff (soft_rst)
      expire |=> pending);

   assert_warm_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
      (warm_flag && !(wr_en && sel_stat && wdata[STAT_WARM])) |=> warm_flag);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import keyed_watchdog_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 8,
   parameter int PULSE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              reset_req
);

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold the 16-bit unlock code");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x20");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              load_cnt;
   logic              pending;
   logic              warm_flag;
   logic              expire;
   logic [DATA_W-1:0] cnt;
   logic              state_rst;

   assign state_rst = !por_n || !warm_rst_n;

   kwd_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .por_n      (por_n),
      .warm_rst_n (warm_rst_n),
      .wr_en      (bus_we),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .cnt_val    (cnt),
      .expire     (expire),
      .ctrl       (ctrl),
      .load_cnt   (load_cnt),
      .pending    (pending),
      .warm_flag  (warm_flag),
      .rdata      (bus_rdata)
   );

   kwd_down_counter #(.DATA_W(DATA_W)) u_count (
      .clk      (clk),
      .rst      (state_rst),
      .load     (load_cnt),
      .load_val (bus_wdata),
      .run      (ctrl.run),
      .cnt      (cnt),
      .expire   (expire)
   );

   // Runs on power-on reset only, so a warm reset driven by this pulse does not cut it short
   kwd_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk     (clk),
      .rst     (!por_n),
      .trigger (expire && ctrl.rst_on),
      .pulse   (reset_req)
   );

   assign irq = pending && ctrl.irq_on;

   assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(reset_req) |-> warm_flag);

   assert_irq_needs_event_R7: assert property (@(posedge clk) disable iff (state_rst)
      $rose(irq) |-> (pending && $past(expire || (pending && !ctrl.irq_on))));

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

   localparam int DW = 32;
   localparam int AW = 8;
   localparam int PC = 4;
   localparam logic [AW-1:0] A_CNT  = 8'h14;
   localparam logic [AW-1:0] A_CTRL = 8'h18;
   localparam logic [AW-1:0] A_KEY  = 8'h1C;
   localparam logic [AW-1:0] A_STAT = 8'h20;
   localparam logic [DW-1:0] CODE   = 32'h0000482E;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          warm_rst_n = 1'b1;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;
   logic          reset_req;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   keyed_watchdog #(.DATA_W(DW), .ADDR_W(AW), .PULSE_CYCLES(PC)) uut (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .reset_req(reset_req)
   );

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] exp_cnt(int n, int k);
      return (k >= n) ? '0 : DW'(n - k);
   endfunction

   function automatic logic exp_rr(bit rst_on, int n, int k);
      return rst_on && (k >= n + 1) && (k <= n + PC);
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   initial begin
      #(5ns * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CNT, v);  check("R1 cnt", v, 0);
      rd(A_CTRL, v); check("R1 ctrl", v, 0);
      rd(A_KEY, v);  check("R1 key", v, 0);
      rd(A_STAT, v); check("R1 stat", v, 0);
      check("R1 irq", DW'(irq), 0);
      check("R1 reset_req", DW'(reset_req), 0);

      // R3 locked writes ignored
      wr(A_CNT, 32'h55);  rd(A_CNT, v);  check("R3 locked cnt", v, 0);
      wr(A_CTRL, 32'h7);  rd(A_CTRL, v); check("R3 locked ctrl", v, 0);

      // R2 key behaviour
      wr(A_KEY, 32'h0001482E); rd(A_KEY, v); check("R2 near code", v, 0);
      wr(A_KEY, CODE);         rd(A_KEY, v); check("R2 unlock", v, 1);
      wr(A_CNT, 32'd100);      rd(A_CNT, v); check("R2 cnt accepted", v, 100);
      wr(A_CTRL, 32'hFFFF_FFFA); rd(A_CTRL, v); check("R4 ctrl bits", v, 2);
      wr(A_KEY, 0);            rd(A_KEY, v); check("R2 relock", v, 0);
      wr(A_CNT, 32'd7);        rd(A_CNT, v); check("R3 relocked cnt", v, 100);

      // R5 hold when stopped
      repeat (5) @(negedge clk);
      rd(A_CNT, v); check("R5 hold stopped", v, 100);

      // Random loads: R4 R5 R6 R7 R8 R9 R10
      for (int it = 0; it < 24; it++) begin
         int n;
         bit irq_on, rst_on;
         logic [DW-1:0] st;
         n = int'($urandom % 30);
         irq_on = 1'($urandom);
         rst_on = 1'($urandom);
         wr(A_KEY, CODE);
         wr(A_CTRL, 0);
         wr(A_CNT, DW'(n));
         wr(A_CTRL, {29'b0, 1'b1, irq_on, rst_on});
         rd(A_CTRL, v); check("R4 ctrl readback", v, {29'b0, 1'b1, irq_on, rst_on});
         for (int k = 1; k <= n + PC + 2; k++) begin
            bit pend;
            @(negedge clk);
            pend = (k >= n + 1);
            rd(A_CNT, v); check("R5 R6 count", v, exp_cnt(n, k));
            rd(A_STAT, v); check("R6 pending", DW'(v[3]), DW'(pend));
            check("R7 irq", DW'(irq), DW'(pend && irq_on));
            check("R8 reset_req", DW'(reset_req), DW'(exp_rr(rst_on, n, k)));
         end
         rd(A_STAT, st);
         check("R9 warm flag", DW'(st[4]), DW'(rst_on));
         wr(A_STAT, 0);
         rd(A_STAT, v); check("R10 zero write keeps", v, st);
         wr(A_STAT, 32'h18);
         rd(A_STAT, v); check("R10 w1c", v, 0);
         check("R8 no second expiry", DW'(reset_req), 0);
         wr(A_CTRL, 0);
         wr(A_KEY, 0);
      end

      // R11 immediate reset request
      wr(A_KEY, CODE);
      wr(A_CNT, 0);
      wr(A_CTRL, 32'h5);
      check("R11 not yet", DW'(reset_req), 0);
      @(negedge clk);
      check("R11 immediate", DW'(reset_req), 1);
      repeat (PC + 1) @(negedge clk);

      // R12 warm reset spares status bit 4
      wr(A_CNT, 32'd50);
      wr(A_CTRL, 32'h3);
      @(negedge clk); warm_rst_n = 1'b0;
      @(negedge clk); warm_rst_n = 1'b1;
      rd(A_CNT, v);  check("R12 cnt", v, 0);
      rd(A_CTRL, v); check("R12 ctrl", v, 0);
      rd(A_KEY, v);  check("R12 key", v, 0);
      rd(A_STAT, v); check("R12 R9 stat keeps warm", v, 32'h10);
      check("R12 irq", DW'(irq), 0);

      // R10 clear without key, then R9 power-on clears
      wr(A_STAT, 32'h10);
      rd(A_STAT, v); check("R10 clear unlocked not needed", v, 0);
      wr(A_KEY, CODE); wr(A_CNT, 0); wr(A_CTRL, 32'h5);
      repeat (PC + 2) @(negedge clk);
      rd(A_STAT, v); check("R9 set again", DW'(v[4]), 1);
      por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(A_STAT, v); check("R9 por clears", v, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule